// File: doc/BRIEF.md
# Transmit Burst Power Ramp

The block multiplies a stream of complex baseband samples by a gain envelope. The envelope values come from a small coefficient table that is written through a simple write port. It shapes the rising and falling edges of a transmit burst, so that power turns on and off smoothly instead of switching abruptly.

A trigger pulse arms the ramp and loads a hold-off down-counter from `hold_val`. The counter then decrements on every system clock. When it reaches one, the ramp starts at the next edge. During the ramp the block applies one table entry to each valid sample, advancing by one entry per sample. A ramp-up walks the table from entry 0 to the last entry and then keeps the last entry. A ramp-down walks from the last entry to entry 0 and then keeps entry 0. Outside a ramp the most recently selected entry scales every sample. A bypass input passes samples through unchanged.

The direction, the length and the length-extension bit are captured when the trigger is accepted. Changing them afterwards has no effect on the ramp already armed.

Top module: `pwr_ramp`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `out_i`, `out_q` and `busy` are all zero, and the table index returns to entry 0.
- R2: `out_vld` equals `in_vld` delayed by one clock. A sample presented at one edge appears on `out_i`/`out_q` after that same edge.
- R3: With bypass low, each output is `sat16(floor((x*g + 2^14) / 2^15))`. Here x is the signed 16-bit sample and g is the signed 16-bit coefficient in 1.15 format. For example, -32768 times -32768 saturates to 32767, and 3 times 16384 gives 2.
- R4: With `byp` high, the outputs equal the inputs exactly, which is unity gain.
- R5: A `trig` pulse with `hold_val` not zero, arriving while idle, raises `busy` at the next edge. A `trig` pulse with `hold_val` equal to 0 is ignored, and `busy` stays low.
- R6: If the trigger is accepted at edge E0, the ramp is entered at edge E0+`hold_val`. The first ramp coefficient applies to samples presented at edge E0+`hold_val`+1 or later. Earlier samples use the held coefficient.
- R7: In a ramp-up (`dir_down`=0), successive valid samples use entries 0, 1, …, last. Idle cycles do not advance the index. `busy` falls at the edge that consumes entry `last`, and later samples keep entry `last`.
- R8: In a ramp-down (`dir_down`=1), successive valid samples use entries last, …, 1, 0. `busy` falls after entry 0 is consumed, and later samples keep entry 0.
- R9: `ramp_len` holds length minus one. With `len_ext`=0, last = min(`ramp_len`, 63), giving at most 64 entries. With `len_ext`=1, last = `ramp_len`, giving up to 128 entries.
- R10: A `trig` pulse arriving while `busy` is high is ignored. The current ramp finishes unchanged.
- R11: `dir_down`, `ramp_len` and `len_ext` are sampled at the accepted trigger. Later changes do not alter that ramp.
- R12: A write with `cw_en` high stores `cw_data` at `cw_addr`. The stored value scales samples presented from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| byp | input | 1 | Unity-gain bypass |
| trig | input | 1 | Ramp trigger pulse |
| hold_val | input | 16 | Hold-off count in clocks, where 0 disables the trigger |
| dir_down | input | 1 | 1 = ramp-down, 0 = ramp-up |
| ramp_len | input | 7 | Ramp length minus one |
| len_ext | input | 1 | Allow lengths up to 128 entries |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | 7 | Coefficient write address |
| cw_data | input | 16 | Coefficient write data, signed 1.15 |
| out_vld | output | 1 | Output sample strobe |
| out_i | output | 16 | Scaled in-phase sample |
| out_q | output | 16 | Scaled quadrature sample |
| busy | output | 1 | High during hold-off and ramp |

## Verification
The assertions check four things on every cycle:
- the one-clock valid pipeline,
- exact pass-through in bypass,
- arming of `busy` by an accepted trigger,
- rejection of triggers that carry a zero hold-off.

Other properties depend on the contents of the table and on a history of many cycles, so only the bench scenarios can show them. These are the exact clock at which the hold-off expires, the order in which entries are walked in each direction, clamping of the length and capture of the settings at the trigger, rejection of a trigger during a ramp, and the rounding and saturation values.

// File: rtl/pwr_ramp.sv
module pwr_ramp #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int HW = 16,
  parameter int AW = 7,
  parameter int SHORT_MAX = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 byp,
  input  logic                 trig,
  input  logic [HW-1:0]        hold_val,
  input  logic                 dir_down,
  input  logic [AW-1:0]        ramp_len,
  input  logic                 len_ext,
  input  logic                 cw_en,
  input  logic [AW-1:0]        cw_addr,
  input  logic signed [CW-1:0] cw_data,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic                 busy
);
  localparam int DEPTH = 1 << AW;
  localparam int FRAC  = CW - 1;
  localparam int PW    = DW + CW;
  localparam logic [AW-1:0]      SHORT_LAST = AW'(SHORT_MAX - 1);
  localparam logic signed [PW:0] HALF = (PW+1)'(1) << (FRAC - 1);
  localparam logic signed [PW:0] MAXV = (PW+1)'((1 << (DW - 1)) - 1);
  localparam logic signed [PW:0] MINV = -MAXV - (PW+1)'(1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RAMP} st_t;

  st_t                 st;
  logic signed [CW-1:0] cmem [DEPTH];
  logic [AW-1:0]       idx, last_q;
  logic                down_q;
  logic [HW-1:0]       cnt;

  wire [AW-1:0] last_d = (len_ext || ramp_len <= SHORT_LAST) ? ramp_len : SHORT_LAST;
  wire          arm    = trig && (st == S_IDLE) && (hold_val != '0);
  wire          at_end = down_q ? (idx == '0) : (idx == last_q);
  wire signed [CW-1:0] gain = cmem[idx];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk)
    if (cw_en) cmem[cw_addr] <= cw_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      last_q <= '0;
      down_q <= 1'b0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (arm) begin
          cnt    <= hold_val;
          last_q <= last_d;
          down_q <= dir_down;
          st     <= S_WAIT;
        end
        S_WAIT: if (cnt == HW'(1)) begin
          st  <= S_RAMP;
          idx <= down_q ? last_q : '0;
        end else begin
          cnt <= cnt - HW'(1);
        end
        S_RAMP: if (in_vld) begin
          if (at_end) st <= S_IDLE;
          else        idx <= down_q ? idx - AW'(1) : idx + AW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                  input logic signed [CW-1:0] g);
    logic signed [PW-1:0] prod;
    logic signed [PW:0]   r;
    logic signed [PW:0]   s;
    prod = x * g;
    r    = {prod[PW-1], prod} + HALF;
    s    = r >>> FRAC;
    if (s > MAXV)      scale = MAXV[DW-1:0];
    else if (s < MINV) scale = MINV[DW-1:0];
    else               scale = s[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_i   <= '0;
      out_q   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_i <= byp ? in_i : scale(in_i, gain);
        out_q <= byp ? in_q : scale(in_q, gain);
      end
    end
  end
endmodule

// File: rtl/pwr_ramp_chk.sv
module pwr_ramp_chk #(
  parameter int DW = 16,
  parameter int HW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 byp,
  input logic                 trig,
  input logic [HW-1:0]        hold_val,
  input logic                 busy,
  input logic                 out_vld,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q
);
  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_bypass_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && byp) |=> (out_i == $past(in_i) && out_q == $past(in_q)));
  p_arm_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy && hold_val != '0) |=> busy);
  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy && hold_val == '0) |=> !busy);
endmodule

bind pwr_ramp pwr_ramp_chk #(.DW(DW), .HW(HW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
  .byp(byp), .trig(trig), .hold_val(hold_val), .busy(busy),
  .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
);

// File: tb/pwr_ramp_tb.sv
module pwr_ramp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 0, byp = 0, trig = 0, dir_down = 0, len_ext = 0, cw_en = 0;
  logic signed [15:0] in_i = 0, in_q = 0, cw_data = 0;
  logic [15:0] hold_val = 0;
  logic [6:0] ramp_len = 0, cw_addr = 0;
  logic out_vld, busy;
  logic signed [15:0] out_i, out_q;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_ramp dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .byp(byp), .trig(trig), .hold_val(hold_val), .dir_down(dir_down),
    .ramp_len(ramp_len), .len_ext(len_ext), .cw_en(cw_en), .cw_addr(cw_addr),
    .cw_data(cw_data), .out_vld(out_vld), .out_i(out_i), .out_q(out_q), .busy(busy)
  );

  // xi, xq, g, expected i, expected q
  localparam int VEC [7][5] = '{
    '{ 16384, -16384,  16384,   8192,  -8192},
    '{-32768,      0, -32768,  32767,      0},
    '{     3,      1,  16384,      2,      1},
    '{    -3,     -1,  16384,     -1,      0},
    '{ 32767, -32767,  32767,  32766, -32766},
    '{  1000,      0, -32768,  -1000,      0},
    '{-32768,      1,  32767, -32767,      1}
  };

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    cw_en = 1; cw_addr = 7'(a); cw_data = 16'(d);
    step();
    cw_en = 0;
  endtask

  task automatic smp(input bit v, input int exp, input string r);
    in_vld = v; in_i = 16384; in_q = -16384;
    step();
    in_vld = 0; trig = 0;
    if (v) begin
      chk(r, out_i, exp);
      chk(r, out_q, -exp);
    end else begin
      chk({r, " R2 no valid"}, out_vld, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 out_vld", out_vld, 0);
    chk("R1 out_i", out_i, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // R3/R12 arithmetic vectors; index 0 is selected after reset
    for (int n = 0; n < 7; n++) begin
      wr(0, VEC[n][2]);
      in_vld = 1; in_i = 16'(VEC[n][0]); in_q = 16'(VEC[n][1]);
      step();
      in_vld = 0;
      chk("R2 out_vld", out_vld, 1);
      chk("R3 i", out_i, VEC[n][3]);
      chk("R3 q", out_q, VEC[n][4]);
    end

    for (int k = 0; k < 128; k++) wr(k, 200 * (k + 1));

    // R6 hold-off timing with a ramp-down of 4 entries (R8)
    ramp_len = 3; dir_down = 1; len_ext = 0; hold_val = 5; trig = 1;
    for (int k = 0; k < 12; k++) begin
      int e;
      e = (k <= 5) ? 100 : (k <= 9) ? 100 * (4 - (k - 6)) : 100;
      smp(1, e, "R6 R8 walk");
      chk("R6 busy", busy, (k <= 8) ? 1 : 0);
    end

    // R7 ramp-up with gaps, R10 trigger during ramp ignored
    hold_val = 1; dir_down = 0; ramp_len = 2; trig = 1;
    smp(0, 0, "R7");
    chk("R5 busy armed", busy, 1);
    smp(0, 0, "R7");
    smp(1, 100, "R7 entry0");
    trig = 1; hold_val = 1; dir_down = 1;
    smp(0, 0, "R10");
    smp(1, 200, "R7 R10 entry1");
    smp(1, 300, "R7 entry2");
    chk("R7 busy end", busy, 0);
    smp(1, 300, "R7 R10 hold last");
    chk("R10 busy", busy, 0);

    // R5 zero hold-off ignored
    hold_val = 0; trig = 1;
    smp(1, 300, "R5 zero hold");
    chk("R5 busy", busy, 0);

    // R9 clamp to 64, R11 capture at trigger
    len_ext = 0; ramp_len = 100; dir_down = 0; hold_val = 1; trig = 1;
    smp(0, 0, "R11");
    len_ext = 1; ramp_len = 127; dir_down = 1;
    smp(0, 0, "R11");
    for (int k = 0; k < 64; k++) smp(1, 100 * (k + 1), "R9 R11 short walk");
    chk("R9 busy", busy, 0);
    smp(1, 6400, "R9 hold 63");

    // R9 extended 128-entry ramp-down
    len_ext = 1; ramp_len = 127; dir_down = 1; hold_val = 2; trig = 1;
    smp(0, 0, "R9"); smp(0, 0, "R9"); smp(0, 0, "R9");
    for (int k = 0; k < 128; k++) smp(1, 100 * (128 - k), "R8 R9 long walk");
    chk("R8 busy", busy, 0);
    smp(1, 100, "R8 hold 0");

    // R12 write to the held entry, R3 saturation
    wr(0, -32768);
    in_vld = 1; in_i = -32768; in_q = 0;
    step(); in_vld = 0;
    chk("R12 R3 sat", out_i, 32767);

    // R4 bypass
    byp = 1; in_vld = 1; in_i = -32768; in_q = 12345;
    step(); in_vld = 0; byp = 0;
    chk("R4 i", out_i, -32768);
    chk("R4 q", out_q, 12345);

    // R1 reset during a ramp
    hold_val = 1; dir_down = 0; ramp_len = 5; trig = 1;
    step(); trig = 0;
    rst_n = 0;
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 out_q", out_q, 0);
    step();
    rst_n = 1;
    step();
    chk("R1 busy after", busy, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule